// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits between an instruction fetch front end and a slow external instruction memory, and its job is to hide that memory's start-up latency after a taken branch. It holds a set of short instruction runs, each tagged with the branch target address where the run starts. When a branch arrives, its target is compared against every tag at once. On a hit, the block issues the five stored instructions one per cycle. Partway through that run, it starts the external memory at the sixth instruction past the target, so that the external stream takes over in the cycle after the last cached word without a gap.

On a miss, the block starts the external memory at the target in the branch cycle itself and forwards instructions as they come back. The memory returns two 16-bit instructions per 32-bit transfer, one transfer every second cycle. The block splits each transfer into two instructions, low half first. While forwarding, it captures the first five instructions into an entry chosen round-robin. The entry becomes valid only after all five have been written. Instruction words are stored as opaque 16-bit values, so coprocessor-class words are cached like any other.

The controller has four states. S_IDLE holds after reset until the first branch. S_RUN issues cached words. S_FILL forwards memory data while capturing it. S_STREAM forwards memory data only.

Transitions:
- A branch moves to S_RUN on a hit and to S_FILL on a miss, from any state.
- S_RUN moves to S_STREAM after its fifth word.
- S_FILL moves to S_STREAM once the fifth word is captured, or when a flush arrives.

Top module: `btic`

## Requirements
- R1: The cache has N (default 32) entries, searched fully associatively on the branch target. A hit requires a valid entry whose tag equals the target, and at most one valid entry ever matches a given target.
- R2: After reset every entry is invalid, `ins_valid` and `mem_start` stay low until the first branch, and that first branch misses.
- R3: On a hit with a branch in cycle b, `ins_valid` is high in cycles b+1 to b+5 and `ins_data` carries the five stored words of the entry (target, target+1, ... target+4) in that order. `mem_start` is low in cycle b.
- R4: On a hit, `mem_start` pulses exactly once, in cycle b+3, with `mem_addr` equal to target+5 (modulo 2^AW). No other start is issued until the next branch.
- R5: Given an external memory whose first transfer arrives 3 cycles after `mem_start`, instruction target+5 appears in cycle b+6, directly after the fifth cached word, and the stream then continues at one instruction per cycle.
- R6: On a miss, `mem_start` is high in cycle b with `mem_addr` equal to the target. Each transfer is forwarded as two instructions: bits 15:0 in the cycle `mem_valid` is high, then bits 31:16 in the next cycle. With the 3-cycle memory, the target appears in cycle b+3 and the stream continues one per cycle.
- R7: The first five instructions forwarded after a miss are stored in the allocated entry. A later branch to the same target hits and returns those stored words, even if external memory content has changed since.
- R8: Misses allocate entries in round-robin order 0, 1, ..., N-1 and then wrap. After N+1 distinct misses, the first target is evicted and misses, while the second still hits.
- R9: A branch that arrives before a fill has captured all five words abandons it. That entry stays invalid, so a later branch to the abandoned target misses.
- R10: A one-cycle `flush` invalidates every entry. A fill in progress during a flush is not committed. A branch in the same cycle as a flush misses.
- R11: Stored words are returned unchanged for every 16-bit value, including words whose top four bits are all ones (coprocessor-class).
- R12: A branch in any cycle, including during a cached run, takes priority. The output switches to the new target's stream in the next cycle, and a start pending from the interrupted run is not issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries this cycle |
| br_valid | input | 1 | Taken branch this cycle |
| br_target | input | AW | Branch target instruction address |
| ins_valid | output | 1 | An instruction is on `ins_data` this cycle |
| ins_data | output | DW | Issued instruction word |
| mem_start | output | 1 | Start external sequential fetch at `mem_addr` |
| mem_addr | output | AW | External fetch start address |
| mem_valid | input | 1 | External transfer present this cycle |
| mem_data | input | 2*DW | Two instructions; lower address in bits 15:0 |

## Verification
The bench drives a cached run that is interrupted by a branch to another cached target in the very cycle the pending external restart would fire. A design that let the stale start through, or issued it on the wrong cycle, would make the external stream begin one or more instructions off. After a hit, the word in cycle b+6 is checked against memory. A restart timed one cycle early or late shows up as a repeated word or as a bubble at the handoff. Memory content is changed between fill and reuse, so an entry that was never really captured, or was captured from the wrong half of a transfer, returns the wrong word. Abandoned fills, flushed fills and a full round-robin wrap must each produce a miss, seen as `mem_start` in the branch cycle. A design that committed partial entries, or that evicted the wrong slot, would hit instead.

// File: rtl/btic_pkg.sv
package btic_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_FILL   = 2'd2,
        S_STREAM = 2'd3
    } btic_state_e;
endpackage

// File: rtl/btic_lookup.sv
module btic_lookup #(
    parameter int N  = 32,
    parameter int AW = 16,
    localparam int XW = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [N-1:0]       vld,
    input  logic [AW-1:0]      key,
    input  logic               en,
    output logic               hit,
    output logic [XW-1:0]      idx
);
    logic [N-1:0] match;

    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = en && vld[g] && (tags[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = idx | XW'(i);
        end
    end

    assign hit = |match;

    // R1: a valid target is never stored twice.
    a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/btic_store.sv
module btic_store #(
    parameter int N   = 32,
    parameter int RUN = 5,
    parameter int AW  = 16,
    parameter int DW  = 16,
    localparam int XW = $clog2(N),
    localparam int CW = $clog2(RUN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 alloc_en,
    input  logic [XW-1:0]        alloc_idx,
    input  logic [AW-1:0]        alloc_tag,
    input  logic                 wr_en,
    input  logic [XW-1:0]        wr_idx,
    input  logic [CW-1:0]        wr_word,
    input  logic [DW-1:0]        wr_data,
    input  logic                 commit_en,
    input  logic [XW-1:0]        commit_idx,
    input  logic [XW-1:0]        rd_idx,
    input  logic [CW-1:0]        rd_word,
    output logic [N-1:0][AW-1:0] tag_q,
    output logic [N-1:0]         vld_q,
    output logic [DW-1:0]        rd_data
);
    logic [DW-1:0] word_q [N][RUN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            tag_q <= '0;
        end else begin
            if (flush) vld_q <= '0;
            if (alloc_en) begin
                vld_q[alloc_idx] <= 1'b0;
                tag_q[alloc_idx] <= alloc_tag;
            end
            if (commit_en) vld_q[commit_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) word_q[wr_idx][wr_word] <= wr_data;
    end

    assign rd_data = word_q[rd_idx][rd_word];

    // R10: nothing survives a flush, not even a fill finishing that cycle.
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_q == '0));
endmodule

// File: rtl/btic_ctrl.sv
module btic_ctrl
    import btic_pkg::*;
#(
    parameter int N   = 32,
    parameter int RUN = 5,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int LAT = 3,
    localparam int XW = $clog2(N),
    localparam int CW = $clog2(RUN),
    localparam int START_AT = RUN - LAT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            br_valid,
    input  logic [AW-1:0]   br_target,
    input  logic            hit,
    input  logic [XW-1:0]   hit_idx,
    input  logic            mem_valid,
    input  logic [2*DW-1:0] mem_data,
    input  logic [DW-1:0]   rd_data,
    output logic [XW-1:0]   rd_idx,
    output logic [CW-1:0]   rd_word,
    output logic            alloc_en,
    output logic [XW-1:0]   alloc_idx,
    output logic            wr_en,
    output logic [XW-1:0]   wr_idx,
    output logic [CW-1:0]   wr_word,
    output logic [DW-1:0]   wr_data,
    output logic            commit_en,
    output logic [XW-1:0]   commit_idx,
    output logic            ins_valid,
    output logic [DW-1:0]   ins_data,
    output logic            mem_start,
    output logic [AW-1:0]   mem_addr
);
    btic_state_e   state, state_d;
    logic [CW-1:0] cnt, fill_cnt;
    logic [XW-1:0] run_idx, fill_idx, rr;
    logic [AW-1:0] base;
    logic          hi_pend;
    logic [DW-1:0] hi_buf;

    // Next state: a branch wins over everything.
    always_comb begin
        state_d = state;
        if (br_valid) begin
            state_d = hit ? S_RUN : S_FILL;
        end else begin
            unique case (state)
                S_IDLE:   state_d = S_IDLE;
                S_RUN:    if (cnt == CW'(RUN - 1)) state_d = S_STREAM;
                S_FILL:   if (flush || (ins_valid && fill_cnt == CW'(RUN - 1)))
                              state_d = S_STREAM;
                S_STREAM: state_d = S_STREAM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            fill_cnt <= '0;
            run_idx  <= '0;
            fill_idx <= '0;
            rr       <= '0;
            base     <= '0;
            hi_pend  <= 1'b0;
            hi_buf   <= '0;
        end else begin
            state <= state_d;
            if (br_valid) begin
                cnt      <= '0;
                fill_cnt <= '0;
                hi_pend  <= 1'b0;
                base     <= br_target;
                if (hit) begin
                    run_idx <= hit_idx;
                end else begin
                    fill_idx <= rr;
                    rr       <= (rr == XW'(N - 1)) ? '0 : rr + XW'(1);
                end
            end else begin
                if (state == S_RUN) cnt <= cnt + CW'(1);
                if (wr_en) fill_cnt <= fill_cnt + CW'(1);
                if (state == S_FILL || state == S_STREAM) begin
                    hi_pend <= mem_valid;
                    if (mem_valid) hi_buf <= mem_data[2*DW-1:DW];
                end else begin
                    hi_pend <= 1'b0;
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        ins_valid = 1'b0;
        ins_data  = '0;
        unique case (state)
            S_IDLE: ;
            S_RUN: begin
                ins_valid = 1'b1;
                ins_data  = rd_data;
            end
            S_FILL, S_STREAM: begin
                ins_valid = mem_valid || hi_pend;
                ins_data  = mem_valid ? mem_data[DW-1:0] : hi_buf;
            end
        endcase

        mem_start = 1'b0;
        mem_addr  = base + AW'(RUN);
        if (br_valid) begin
            mem_start = !hit;
            mem_addr  = br_target;
        end else if (state == S_RUN && cnt == CW'(START_AT)) begin
            mem_start = 1'b1;
        end

        rd_idx     = run_idx;
        rd_word    = cnt;
        alloc_en   = br_valid && !hit;
        alloc_idx  = rr;
        wr_en      = (state == S_FILL) && ins_valid && !br_valid && !flush;
        wr_idx     = fill_idx;
        wr_word    = fill_cnt;
        wr_data    = ins_data;
        commit_en  = wr_en && (fill_cnt == CW'(RUN - 1));
        commit_idx = fill_idx;
    end

    // R3: a hit issues a cached word from the hit entry in the next cycle.
    a_r3_hit_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && hit) |=> (state == S_RUN && ins_valid && rd_idx == $past(hit_idx)));

    // R5: the cached run hands over to the external stream with no idle state.
    a_r5_run_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && cnt == CW'(RUN - 1) && !br_valid) |=> (state == S_STREAM));

    // R4: outside a branch cycle, a start only comes from a cached run.
    a_r4_start_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_start && !br_valid) |-> (state == S_RUN));

    // R9: a new branch never lets a partial fill commit.
    a_r9_no_commit_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> !commit_en);
endmodule

// File: rtl/btic.sv
module btic #(
    parameter int N   = 32,
    parameter int RUN = 5,
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int LAT = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            br_valid,
    input  logic [AW-1:0]   br_target,
    output logic            ins_valid,
    output logic [DW-1:0]   ins_data,
    output logic            mem_start,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_valid,
    input  logic [2*DW-1:0] mem_data
);
    localparam int XW = $clog2(N);
    localparam int CW = $clog2(RUN);

    logic [N-1:0][AW-1:0] tag_q;
    logic [N-1:0]         vld_q;
    logic                 hit, lk_en;
    logic [XW-1:0]        hit_idx, rd_idx, alloc_idx, wr_idx, commit_idx;
    logic [CW-1:0]        rd_word, wr_word;
    logic [DW-1:0]        rd_data, wr_data;
    logic                 alloc_en, wr_en, commit_en;

    assign lk_en = br_valid && !flush;

    btic_lookup #(.N(N), .AW(AW)) u_lookup (
        .clk (clk), .rst_n(rst_n), .tags(tag_q), .vld(vld_q),
        .key (br_target), .en(lk_en), .hit(hit), .idx(hit_idx)
    );

    btic_store #(.N(N), .RUN(RUN), .AW(AW), .DW(DW)) u_store (
        .clk       (clk),       .rst_n     (rst_n),     .flush    (flush),
        .alloc_en  (alloc_en),  .alloc_idx (alloc_idx), .alloc_tag(br_target),
        .wr_en     (wr_en),     .wr_idx    (wr_idx),    .wr_word  (wr_word),
        .wr_data   (wr_data),   .commit_en (commit_en), .commit_idx(commit_idx),
        .rd_idx    (rd_idx),    .rd_word   (rd_word),
        .tag_q     (tag_q),     .vld_q     (vld_q),     .rd_data  (rd_data)
    );

    btic_ctrl #(.N(N), .RUN(RUN), .AW(AW), .DW(DW), .LAT(LAT)) u_ctrl (
        .clk       (clk),       .rst_n     (rst_n),     .flush     (flush),
        .br_valid  (br_valid),  .br_target (br_target), .hit       (hit),
        .hit_idx   (hit_idx),   .mem_valid (mem_valid), .mem_data  (mem_data),
        .rd_data   (rd_data),   .rd_idx    (rd_idx),    .rd_word   (rd_word),
        .alloc_en  (alloc_en),  .alloc_idx (alloc_idx), .wr_en     (wr_en),
        .wr_idx    (wr_idx),    .wr_word   (wr_word),   .wr_data   (wr_data),
        .commit_en (commit_en), .commit_idx(commit_idx),
        .ins_valid (ins_valid), .ins_data  (ins_data),
        .mem_start (mem_start), .mem_addr  (mem_addr)
    );
endmodule

// File: tb/btic_bench.sv
module btic_bench;
    localparam int RUN = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic        br_valid;
    logic [15:0] br_target;
    logic        ins_valid;
    logic [15:0] ins_data;
    logic        mem_start;
    logic [15:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;
    int gen   = 1;
    int allocs = 0;

    always #4 clk = ~clk;

    btic u_btic (
        .clk(clk), .rst_n(rst_n), .flush(flush), .br_valid(br_valid),
        .br_target(br_target), .ins_valid(ins_valid), .ins_data(ins_data),
        .mem_start(mem_start), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_data(mem_data)
    );

    // Content of external memory; generation 7 makes coprocessor-class words.
    function automatic logic [15:0] mem_word(input logic [15:0] a, input int g);
        logic [15:0] h;
        h = a * 16'h9E37 + 16'(g) * 16'h1357;
        return (g == 7) ? {4'hF, h[11:0]} : h;
    endfunction

    // External memory: first transfer 3 cycles after a start, then every 2nd cycle.
    logic [15:0] m_ptr;
    int          m_age;
    bit          m_on;
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_data  <= '0;
            m_on      <= 1'b0;
            m_age     <= 0;
            m_ptr     <= '0;
        end else if (mem_start) begin
            m_ptr     <= mem_addr;
            m_age     <= 1;
            m_on      <= 1'b1;
            mem_valid <= 1'b0;
        end else if (m_on) begin
            m_age <= m_age + 1;
            if (m_age >= 2 && ((m_age - 2) % 2 == 0)) begin
                mem_valid <= 1'b1;
                mem_data  <= {mem_word(m_ptr + 16'd1, gen), mem_word(m_ptr, gen)};
                m_ptr     <= m_ptr + 16'd2;
            end else begin
                mem_valid <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called at a negedge. Branch in cycle b, then check ncyc cycles b+1...
    task automatic run_branch(input logic [15:0] t, input bit exp_hit, input int fill_gen,
                              input int ncyc, input string req, input bit fl = 1'b0);
        br_valid  = 1'b1;
        br_target = t;
        flush     = fl;
        #1;
        if (exp_hit)
            chk(mem_start == 1'b0, {req, "/R3"}, "no start on hit", {31'd0, mem_start}, 32'd0);
        else
            chk(mem_start == 1'b1 && mem_addr == t, {req, "/R6"}, "miss start",
                {15'd0, mem_start, mem_addr}, {15'd0, 1'b1, t});
        @(negedge clk);
        br_valid = 1'b0;
        flush    = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            logic        ev, es;
            logic [15:0] ed, ea;
            string       rq;
            #1;
            if (exp_hit) begin
                ev = 1'b1;
                ed = (k < RUN) ? mem_word(t + 16'(k), fill_gen) : mem_word(t + 16'(k), gen);
                rq = (k < RUN) ? {req, "/R3"} : {req, "/R5"};
                es = (k == 2);
                ea = t + 16'd5;
            end else begin
                ev = (k >= 2);
                ed = mem_word(t + 16'(k) - 16'd2, gen);
                rq = {req, "/R6"};
                es = 1'b0;
                ea = '0;
            end
            chk(ins_valid == ev && (!ev || ins_data == ed), rq, $sformatf("word k=%0d", k),
                {15'd0, ins_valid, ins_data}, {15'd0, ev, ed});
            chk(mem_start == es && (!es || mem_addr == ea), {req, "/R4"},
                $sformatf("start k=%0d", k), {15'd0, mem_start, mem_addr}, {15'd0, es, ea});
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(ins_valid == 1'b0 && mem_start == 1'b0, "R2", "idle after reset",
                {30'd0, ins_valid, mem_start}, 32'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_fill_and_hit();
        gen = 1;
        run_branch(16'h0100, 1'b0, 0, 10, "R2");      // first branch misses
        allocs++;
        gen = 2;                                       // memory changes; entry must not
        run_branch(16'h0100, 1'b1, 1, 10, "R7");
        run_branch(16'h0230, 1'b0, 0, 10, "R6");
        allocs++;
    endtask

    task automatic t_redirect();
        // R12: branch to another cached target in the cycle the restart would fire
        run_branch(16'h0100, 1'b1, 1, 2, "R12");
        run_branch(16'h0230, 1'b1, 2, 10, "R12");
    endtask

    task automatic t_abandon();
        run_branch(16'h0377, 1'b0, 0, 4, "R9");        // only two words captured
        allocs++;
        run_branch(16'h04A0, 1'b0, 0, 10, "R9");
        allocs++;
        run_branch(16'h0377, 1'b0, 0, 10, "R9");       // abandoned target misses
        allocs++;
    endtask

    task automatic t_round_robin();
        // fill until the pointer wraps and one more miss reuses entry 0 (0x0100)
        int need;
        need = 33 - allocs;
        for (int i = 0; i < need; i++) begin
            run_branch(16'h8000 + 16'(i * 8), 1'b0, 0, 8, "R8");
            allocs++;
        end
        run_branch(16'h0230, 1'b1, 2, 8, "R8");        // entry 1 survives
        run_branch(16'h0100, 1'b0, 0, 8, "R8");        // entry 0 evicted
    endtask

    task automatic t_coproc_words();
        gen = 7;
        run_branch(16'h0ABC, 1'b0, 0, 10, "R11");
        gen = 8;
        #1;
        chk(mem_word(16'h0ABC, 7) != mem_word(16'h0ABC, 8), "R11", "gens differ",
            {16'd0, mem_word(16'h0ABC, 7)}, {16'd0, mem_word(16'h0ABC, 8)});
        @(negedge clk);
        run_branch(16'h0ABC, 1'b1, 7, 10, "R11");
    endtask

    task automatic t_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        run_branch(16'h0ABC, 1'b0, 0, 10, "R10");      // flushed, now refilled (gen 8)
        run_branch(16'h0ABC, 1'b0, 0, 10, "R10", 1'b1); // flush with branch: miss
        run_branch(16'h0C00, 1'b0, 0, 4, "R10");
        flush = 1'b1;                                  // flush in the middle of a fill
        @(negedge clk);
        flush = 1'b0;
        repeat (6) @(negedge clk);
        run_branch(16'h0C00, 1'b0, 0, 10, "R10");
    endtask

    initial begin
        rst_n     = 1'b0;
        flush     = 1'b0;
        br_valid  = 1'b0;
        br_target = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_and_hit();
        t_redirect();
        t_abandon();
        t_round_robin();
        t_coproc_words();
        t_flush();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule